// File: doc/BRIEF.md
# Console Command Sequencer

This block sits between a host that issues console commands and the control port of a processor core. Each host command either updates local state or becomes one request on the control port. The local state is an address register, an I/O-page base register and three timeout limits. Port commands cover register, status-word and memory transfers, I/O-page transfers, start, stop, continue, single step and reset. After a request has gone out, the block waits until a completion condition that depends on the command kind is met. It then returns a one-cycle response carrying the captured flags, the read data, a cycle count and an optional masked compare result.

If a wait goes on past its programmed limit, the block reports a timeout and pulses a reset to the port. It then refuses commands for a fixed hold-off period. A combined "load PC and start" command runs as a register write followed automatically by a start request.

Top module: `cps_seq`

## Requirements
- R1: A command is taken on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is high only while no command is in progress. For a port command, `cp_req_o` is high for exactly the one cycle after the accepting edge. During that cycle the function, register number, address, byte enables, flags and data are valid. Op codes: 0 rreg, 1 wreg, 2 rpsw, 3 wpsw, 4 rmem, 5 wmem, 6 rmem+inc, 7 wmem+inc, 8 io-read, 9 io-write, 10 start, 11 stop, 12 continue, 13 step, 14 core reset, 15 load-PC-and-start, 16 wait-run-end, 17 set-addr-low, 18 set-addr-high, 19 set-io-base, 20 set-cmd-timeout, 21 set-step-timeout, 22 set-run-timeout. Port function codes: 0 rreg, 1 wreg, 2 rpsw, 3 wpsw, 4 rmem, 5 wmem, 6 start, 7 stop, 8 continue, 9 step, 10 reset.
- R2: Set-addr-low first zeroes the entire address register, including bits 21:16 and both the 22-bit-mode and map enables. It then loads address bits 15:1 from data bits 15:1.
- R3: Set-addr-high loads address bits 21:16 from data bits 5:0, the 22-bit-mode enable from data bit 6 and the map enable from data bit 7. Address bits 15:1 are left as they were.
- R4: Register, status-word and memory requests issue the stored address and enables, with `cp_be_o` = 11 and `cp_racc_o` = 0.
- R5: Set-io-base stores data bits 12:6 as the base. It stores data bits 1:0 as the I/O byte enable, except that 00 is stored as 11.
- R6: An I/O-page request (op 8 read as function 4, op 9 write as function 5) drives address bits 15:13 = 111, bits 12:6 = base, bits 5:1 = `cmd_woff_i` and all other bits 0. It also drives `cp_racc_o` = 1, both enables low and `cp_be_o` = the stored I/O byte enable.
- R7: When an auto-increment memory command completes, the address register advances by one word (+2 in byte address). It does not advance when the command times out.
- R8: Ordinary commands complete on `cp_ack_i`. Step completes when `cp_busy_i` and `cp_step_i` are both low. Wait-run-end completes when `cp_busy_i` and `cp_go_i` are both low, and it issues no request.
- R9: On the edge where completion is detected, the block registers `cp_dout_i` and the error, run, step and halt flags. `rsp_valid_o` is high for the next cycle only. `rsp_cycles_o` gives the number of waiting cycles, counting the request cycle as 1.
- R10: `rsp_chk_fail_o` is 1 when checking was requested and ((read data XOR command data) AND NOT mask) is nonzero. Otherwise it is 0.
- R11: The timeout limits are 50 (ordinary), 100 (step) and 5000 (run end) after reset, and ops 20–22 reprogram them. A wait that reaches its limit without completing responds with `rsp_timeout_o` = 1 and `rsp_cycles_o` = limit.
- R12: On a timeout, `cp_rst_o` is high for one cycle, which is the response cycle. `cmd_ready_o` stays low for 9 further cycles and returns high in the 10th.
- R13: Load-PC-and-start issues a register write to register 7 with the command data. In the cycle after that write completes, the block issues a start request, and each of the two requests gets its own response.
- R14: After reset, `cmd_ready_o` is high, `cp_req_o`, `cp_rst_o` and `rsp_valid_o` are low, the address is zero and the I/O byte enable is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cmd_valid_i | input | 1 | host command present |
| cmd_ready_o | output | 1 | sequencer idle, command can be taken |
| cmd_op_i | input | 5 | command op code |
| cmd_data_i | input | DW | write data, expected read data or setting |
| cmd_rnum_i | input | 3 | register number |
| cmd_woff_i | input | 5 | I/O-page word offset (address bits 5:1) |
| cmd_chk_i | input | 1 | compare read data |
| cmd_mask_i | input | DW | don't-care bits for compare |
| cp_req_o | output | 1 | port request strobe |
| cp_func_o | output | 4 | port function code |
| cp_rnum_o | output | 3 | port register number |
| cp_addr_o | output | AW | port byte address |
| cp_racc_o | output | 1 | remote (I/O-page) access |
| cp_be_o | output | 2 | byte enables |
| cp_ena22_o | output | 1 | 22-bit mode enable |
| cp_map_o | output | 1 | bus map enable |
| cp_din_o | output | DW | port write data |
| cp_rst_o | output | 1 | timeout reset pulse |
| cp_ack_i | input | 1 | port acknowledge |
| cp_busy_i | input | 1 | port busy |
| cp_err_i | input | 1 | command error |
| cp_merr_i | input | 1 | memory error |
| cp_go_i | input | 1 | core running |
| cp_step_i | input | 1 | core stepping |
| cp_halt_i | input | 1 | core halted |
| cp_dout_i | input | DW | port read data |
| rsp_valid_o | output | 1 | response strobe |
| rsp_cycles_o | output | TW | waiting cycles |
| rsp_timeout_o | output | 1 | wait timed out |
| rsp_err_o | output | 1 | captured command error |
| rsp_merr_o | output | 1 | captured memory error |
| rsp_chk_fail_o | output | 1 | compare mismatch |
| rsp_go_o | output | 1 | captured run flag |
| rsp_step_o | output | 1 | captured step flag |
| rsp_halt_o | output | 1 | captured halt flag |
| rsp_data_o | output | DW | captured read data |

## Verification
The request is due in the first cycle after the accepting edge. The bench samples each result at the falling edge of the cycle in which it is due. It checks the request there, and again one cycle later to confirm the strobe has dropped. The bench raises the completion condition in wait cycle d, so the response is due in the cycle after edge d and must report d cycles, or the limit if d lies beyond it. On a timeout the bench samples the reset pulse in the response cycle, then expects `cmd_ready_o` low for nine more cycles and high in the tenth. The chained start request is expected in the same cycle as the first response.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [4:0] {
    OP_RREG = 5'd0,  OP_WREG = 5'd1,  OP_RPSW = 5'd2,  OP_WPSW = 5'd3,
    OP_RMEM = 5'd4,  OP_WMEM = 5'd5,  OP_RMEMI = 5'd6, OP_WMEMI = 5'd7,
    OP_RIO  = 5'd8,  OP_WIO  = 5'd9,  OP_START = 5'd10, OP_STOP = 5'd11,
    OP_CONT = 5'd12, OP_STEP = 5'd13, OP_CRST = 5'd14, OP_LDPC = 5'd15,
    OP_WRUN = 5'd16, OP_ALO  = 5'd17, OP_AHI  = 5'd18, OP_IOB  = 5'd19,
    OP_TCMD = 5'd20, OP_TSTP = 5'd21, OP_TRUN = 5'd22
  } op_e;

  typedef enum logic [3:0] {
    F_RREG = 4'd0, F_WREG = 4'd1, F_RPSW = 4'd2, F_WPSW = 4'd3,
    F_RMEM = 4'd4, F_WMEM = 4'd5, F_STA  = 4'd6, F_STO  = 4'd7,
    F_CONT = 4'd8, F_STEP = 4'd9, F_RST  = 4'd10
  } func_e;

  typedef enum logic [1:0] {W_ACK = 2'd0, W_STEP = 2'd1, W_RUN = 2'd2} wait_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RST, S_HOLD} state_e;
endpackage

// File: rtl/cps_addr_regs.sv
module cps_addr_regs #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          wr_io_i,
  input  logic          inc_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic          ena22_o,
  output logic          map_o,
  output logic [6:0]    io_base_o,
  output logic [1:0]    io_be_o
);
  localparam int HW = AW - 16;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      ena22_o <= 1'b0;
      map_o   <= 1'b0;
    end else if (wr_lo_i) begin
      addr_o  <= {{HW{1'b0}}, data_i[15:1], 1'b0};
      ena22_o <= 1'b0;
      map_o   <= 1'b0;
    end else if (wr_hi_i) begin
      addr_o[AW-1:16] <= data_i[HW-1:0];
      ena22_o         <= data_i[HW];
      map_o           <= data_i[HW+1];
    end else if (inc_i) begin
      addr_o <= addr_o + AW'(2);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_base_o <= '0;
      io_be_o   <= 2'b11;
    end else if (wr_io_i) begin
      io_base_o <= data_i[12:6];
      io_be_o   <= (data_i[1:0] == 2'b00) ? 2'b11 : data_i[1:0];
    end
  end

  // R5
  io_be_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_be_o != 2'b00);

  // R7
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_lo_i && !wr_hi_i) |=> addr_o == $past(addr_o) + AW'(2));
endmodule

// File: rtl/cps_limits.sv
module cps_limits
  import cps_pkg::*;
#(
  parameter int TW      = 16,
  parameter int TO_CMD  = 50,
  parameter int TO_STEP = 100,
  parameter int TO_RUN  = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    set_i,
  input  logic [TW-1:0] data_i,
  input  wait_e         kind_i,
  output logic [TW-1:0] limit_o
);
  localparam logic [TW-1:0] DEF_CMD  = TW'(TO_CMD);
  localparam logic [TW-1:0] DEF_STEP = TW'(TO_STEP);
  localparam logic [TW-1:0] DEF_RUN  = TW'(TO_RUN);

  logic [TW-1:0] lim_q [3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q[0] <= DEF_CMD;
      lim_q[1] <= DEF_STEP;
      lim_q[2] <= DEF_RUN;
    end else begin
      for (int i = 0; i < 3; i++)
        if (set_i[i]) lim_q[i] <= data_i;
    end
  end

  always_comb begin
    case (kind_i)
      W_STEP:  limit_o = lim_q[1];
      W_RUN:   limit_o = lim_q[2];
      default: limit_o = lim_q[0];
    endcase
  end
endmodule

// File: rtl/cps_seq.sv
module cps_seq
  import cps_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 16,
  parameter int TW       = 16,
  parameter int TO_CMD   = 50,
  parameter int TO_STEP  = 100,
  parameter int TO_RUN   = 5000,
  parameter int HOLD_CYC = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [4:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic [2:0]    cmd_rnum_i,
  input  logic [4:0]    cmd_woff_i,
  input  logic          cmd_chk_i,
  input  logic [DW-1:0] cmd_mask_i,
  output logic          cp_req_o,
  output logic [3:0]    cp_func_o,
  output logic [2:0]    cp_rnum_o,
  output logic [AW-1:0] cp_addr_o,
  output logic          cp_racc_o,
  output logic [1:0]    cp_be_o,
  output logic          cp_ena22_o,
  output logic          cp_map_o,
  output logic [DW-1:0] cp_din_o,
  output logic          cp_rst_o,
  input  logic          cp_ack_i,
  input  logic          cp_busy_i,
  input  logic          cp_err_i,
  input  logic          cp_merr_i,
  input  logic          cp_go_i,
  input  logic          cp_step_i,
  input  logic          cp_halt_i,
  input  logic [DW-1:0] cp_dout_i,
  output logic          rsp_valid_o,
  output logic [TW-1:0] rsp_cycles_o,
  output logic          rsp_timeout_o,
  output logic          rsp_err_o,
  output logic          rsp_merr_o,
  output logic          rsp_chk_fail_o,
  output logic          rsp_go_o,
  output logic          rsp_step_o,
  output logic          rsp_halt_o,
  output logic [DW-1:0] rsp_data_o
);
  localparam int HW = AW - 16;

  state_e        state_q;
  wait_e         kind_q;
  logic [TW-1:0] cnt_q, limit;
  logic          chain_q, inc_q, chk_q;
  logic [DW-1:0] exp_q, msk_q;

  // command decode
  logic       dec_port, dec_req, dec_io, dec_inc, dec_chain;
  logic       set_lo, set_hi, set_io;
  logic [2:0] set_lim, dec_rnum;
  logic [3:0] dec_func;
  wait_e      dec_kind;

  always_comb begin
    dec_port = 1'b0; dec_req = 1'b1; dec_io = 1'b0; dec_inc = 1'b0;
    dec_chain = 1'b0; dec_func = F_RREG; dec_kind = W_ACK; dec_rnum = cmd_rnum_i;
    set_lo = 1'b0; set_hi = 1'b0; set_io = 1'b0; set_lim = 3'b000;
    case (cmd_op_i)
      OP_RREG:  begin dec_port = 1'b1; dec_func = F_RREG; end
      OP_WREG:  begin dec_port = 1'b1; dec_func = F_WREG; end
      OP_RPSW:  begin dec_port = 1'b1; dec_func = F_RPSW; end
      OP_WPSW:  begin dec_port = 1'b1; dec_func = F_WPSW; end
      OP_RMEM:  begin dec_port = 1'b1; dec_func = F_RMEM; end
      OP_WMEM:  begin dec_port = 1'b1; dec_func = F_WMEM; end
      OP_RMEMI: begin dec_port = 1'b1; dec_func = F_RMEM; dec_inc = 1'b1; end
      OP_WMEMI: begin dec_port = 1'b1; dec_func = F_WMEM; dec_inc = 1'b1; end
      OP_RIO:   begin dec_port = 1'b1; dec_func = F_RMEM; dec_io = 1'b1; end
      OP_WIO:   begin dec_port = 1'b1; dec_func = F_WMEM; dec_io = 1'b1; end
      OP_START: begin dec_port = 1'b1; dec_func = F_STA; end
      OP_STOP:  begin dec_port = 1'b1; dec_func = F_STO; end
      OP_CONT:  begin dec_port = 1'b1; dec_func = F_CONT; end
      OP_STEP:  begin dec_port = 1'b1; dec_func = F_STEP; dec_kind = W_STEP; end
      OP_CRST:  begin dec_port = 1'b1; dec_func = F_RST; end
      OP_LDPC:  begin dec_port = 1'b1; dec_func = F_WREG; dec_rnum = 3'd7; dec_chain = 1'b1; end
      OP_WRUN:  begin dec_port = 1'b1; dec_req = 1'b0; dec_kind = W_RUN; end
      OP_ALO:   set_lo = 1'b1;
      OP_AHI:   set_hi = 1'b1;
      OP_IOB:   set_io = 1'b1;
      OP_TCMD:  set_lim = 3'b001;
      OP_TSTP:  set_lim = 3'b010;
      OP_TRUN:  set_lim = 3'b100;
      default: ;
    endcase
  end

  logic accept;
  assign cmd_ready_o = (state_q == S_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;

  // completion condition per wait kind
  logic cond, done, expire;
  always_comb begin
    case (kind_q)
      W_STEP:  cond = !cp_busy_i && !cp_step_i;
      W_RUN:   cond = !cp_busy_i && !cp_go_i;
      default: cond = cp_ack_i;
    endcase
  end
  assign done   = (state_q == S_WAIT) && cond;
  assign expire = (state_q == S_WAIT) && !cond && (cnt_q >= limit);

  logic [AW-1:0] reg_addr, io_addr;
  logic          reg_e22, reg_map;
  logic [6:0]    io_base;
  logic [1:0]    io_be;

  cps_addr_regs #(.AW(AW), .DW(DW)) i_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (accept && set_lo),
    .wr_hi_i   (accept && set_hi),
    .wr_io_i   (accept && set_io),
    .inc_i     (done && inc_q),
    .data_i    (cmd_data_i),
    .addr_o    (reg_addr),
    .ena22_o   (reg_e22),
    .map_o     (reg_map),
    .io_base_o (io_base),
    .io_be_o   (io_be)
  );

  assign io_addr = {{HW{1'b0}}, 3'b111, io_base, cmd_woff_i, 1'b0};

  cps_limits #(.TW(TW), .TO_CMD(TO_CMD), .TO_STEP(TO_STEP), .TO_RUN(TO_RUN)) i_lim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (accept ? set_lim : 3'b000),
    .data_i  (cmd_data_i[TW-1:0]),
    .kind_i  (kind_q),
    .limit_o (limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; kind_q <= W_ACK; cnt_q <= '0;
      chain_q <= 1'b0; inc_q <= 1'b0; chk_q <= 1'b0; exp_q <= '0; msk_q <= '0;
      cp_req_o <= 1'b0; cp_func_o <= F_RREG; cp_rnum_o <= '0; cp_addr_o <= '0;
      cp_racc_o <= 1'b0; cp_be_o <= 2'b11; cp_ena22_o <= 1'b0; cp_map_o <= 1'b0;
      cp_din_o <= '0;
    end else begin
      cp_req_o <= 1'b0;
      case (state_q)
        S_IDLE: if (accept && dec_port) begin
          state_q    <= S_WAIT;
          cnt_q      <= TW'(1);
          kind_q     <= dec_kind;
          chain_q    <= dec_chain;
          inc_q      <= dec_inc;
          chk_q      <= cmd_chk_i;
          exp_q      <= cmd_data_i;
          msk_q      <= cmd_mask_i;
          cp_req_o   <= dec_req;
          cp_func_o  <= dec_func;
          cp_rnum_o  <= dec_rnum;
          cp_din_o   <= cmd_data_i;
          cp_addr_o  <= dec_io ? io_addr : reg_addr;
          cp_racc_o  <= dec_io;
          cp_be_o    <= dec_io ? io_be : 2'b11;
          cp_ena22_o <= dec_io ? 1'b0 : reg_e22;
          cp_map_o   <= dec_io ? 1'b0 : reg_map;
        end
        S_WAIT: begin
          if (done && chain_q) begin
            // follow the PC write with a start request
            chain_q   <= 1'b0;
            chk_q     <= 1'b0;
            inc_q     <= 1'b0;
            kind_q    <= W_ACK;
            cnt_q     <= TW'(1);
            cp_req_o  <= 1'b1;
            cp_func_o <= F_STA;
          end else if (done) begin
            state_q <= S_IDLE;
          end else if (expire) begin
            state_q <= S_RST;
          end else begin
            cnt_q <= cnt_q + TW'(1);
          end
        end
        S_RST: begin
          state_q <= S_HOLD;
          cnt_q   <= TW'(1);
        end
        default: begin
          if (cnt_q == TW'(HOLD_CYC)) state_q <= S_IDLE;
          else cnt_q <= cnt_q + TW'(1);
        end
      endcase
    end
  end

  assign cp_rst_o = (state_q == S_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0; rsp_cycles_o <= '0; rsp_timeout_o <= 1'b0;
      rsp_err_o <= 1'b0; rsp_merr_o <= 1'b0; rsp_chk_fail_o <= 1'b0;
      rsp_go_o <= 1'b0; rsp_step_o <= 1'b0; rsp_halt_o <= 1'b0; rsp_data_o <= '0;
    end else begin
      rsp_valid_o <= done || expire;
      if (done || expire) begin
        rsp_cycles_o   <= cnt_q;
        rsp_timeout_o  <= expire;
        rsp_err_o      <= cp_err_i;
        rsp_merr_o     <= cp_merr_i;
        rsp_go_o       <= cp_go_i;
        rsp_step_o     <= cp_step_i;
        rsp_halt_o     <= cp_halt_i;
        rsp_data_o     <= cp_dout_i;
        rsp_chk_fail_o <= done && chk_q && (|((cp_dout_i ^ exp_q) & ~msk_q));
      end
    end
  end

  // R1
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_req_o |=> (!cp_req_o || (cp_func_o == F_STA && $past(cp_func_o) == F_WREG)));

  // R1
  req_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_req_o |-> !cmd_ready_o);

  // R6
  io_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_req_o && cp_racc_o) |-> (cp_addr_o[15:13] == 3'b111 && !cp_ena22_o && !cp_map_o));

  // R12
  rst_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_rst_o |-> (rsp_valid_o && rsp_timeout_o));

  // R12
  rst_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_rst_o |=> (!cp_rst_o && !cmd_ready_o));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !cp_req_o) |=> !rsp_valid_o);
endmodule

// File: tb/test_cps_seq.sv
module test_cps_seq;
  import cps_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 0, cmd_ready, cmd_chk = 0;
  logic [4:0]  cmd_op = 0, cmd_woff = 0;
  logic [15:0] cmd_data = 0, cmd_mask = 0;
  logic [2:0]  cmd_rnum = 0;
  logic        cp_req, cp_racc, cp_e22, cp_map, cp_rst;
  logic [3:0]  cp_func;
  logic [2:0]  cp_rnum;
  logic [21:0] cp_addr;
  logic [1:0]  cp_be;
  logic [15:0] cp_din;
  logic        ack = 0, busy = 0, err = 0, merr = 0, gof = 0, stepf = 0, halt = 0;
  logic [15:0] dout = 0;
  logic        rsp_valid, rsp_to, rsp_err, rsp_merr, rsp_cf, rsp_go, rsp_step, rsp_halt;
  logic [15:0] rsp_cycles, rsp_data;

  cps_seq i_cps_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .cmd_rnum_i(cmd_rnum), .cmd_woff_i(cmd_woff),
    .cmd_chk_i(cmd_chk), .cmd_mask_i(cmd_mask),
    .cp_req_o(cp_req), .cp_func_o(cp_func), .cp_rnum_o(cp_rnum), .cp_addr_o(cp_addr),
    .cp_racc_o(cp_racc), .cp_be_o(cp_be), .cp_ena22_o(cp_e22), .cp_map_o(cp_map),
    .cp_din_o(cp_din), .cp_rst_o(cp_rst),
    .cp_ack_i(ack), .cp_busy_i(busy), .cp_err_i(err), .cp_merr_i(merr),
    .cp_go_i(gof), .cp_step_i(stepf), .cp_halt_i(halt), .cp_dout_i(dout),
    .rsp_valid_o(rsp_valid), .rsp_cycles_o(rsp_cycles), .rsp_timeout_o(rsp_to),
    .rsp_err_o(rsp_err), .rsp_merr_o(rsp_merr), .rsp_chk_fail_o(rsp_cf),
    .rsp_go_o(rsp_go), .rsp_step_o(rsp_step), .rsp_halt_o(rsp_halt), .rsp_data_o(rsp_data)
  );

  int nchk = 0, nerr = 0;
  // bench model of local state
  logic [21:0] m_addr = 0;
  logic        m_e22 = 0, m_map = 0;
  logic [6:0]  m_base = 0;
  logic [1:0]  m_be = 2'b11;
  int          lim_cmd = 50, lim_stp = 100, lim_run = 5000;

  task automatic ceq(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic exp_cf(input logic chk, input logic [15:0] d,
                                  input logic [15:0] e, input logic [15:0] m);
    return chk && (((d ^ e) & ~m) != 16'h0);
  endfunction

  task automatic send(input logic [4:0] op, input logic [15:0] data, input logic [2:0] rnum,
                      input logic [4:0] woff, input logic chk, input logic [15:0] mask);
    cmd_valid = 1; cmd_op = op; cmd_data = data; cmd_rnum = rnum;
    cmd_woff = woff; cmd_chk = chk; cmd_mask = mask;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic local_op(input logic [4:0] op, input logic [15:0] data);
    send(op, data, 3'd0, 5'd0, 1'b0, 16'h0);
    case (op)
      OP_ALO: begin m_addr = {6'b0, data[15:1], 1'b0}; m_e22 = 0; m_map = 0; end
      OP_AHI: begin m_addr[21:16] = data[5:0]; m_e22 = data[6]; m_map = data[7]; end
      OP_IOB: begin m_base = data[12:6]; m_be = (data[1:0] == 2'b00) ? 2'b11 : data[1:0]; end
      OP_TCMD: lim_cmd = int'(data);
      OP_TSTP: lim_stp = int'(data);
      OP_TRUN: lim_run = int'(data);
      default: ;
    endcase
  endtask

  // waits for completion raised in wait cycle dly (0 = never)
  task automatic wait_done(input int dly, input logic [15:0] dv, input logic ev, input int kind,
                           input int lim, input logic chk, input logic [15:0] ed,
                           input logic [15:0] msk, input logic chain, output logic to);
    int got = 0;
    int ec;
    for (int k = 1; k <= lim + 1; k++) begin
      if (k == dly) begin
        dout = dv; err = ev;
        if (kind == 0) ack = 1;
        else if (kind == 1) begin busy = 0; stepf = 0; end
        else begin busy = 0; gof = 0; end
      end
      @(posedge clk); @(negedge clk);
      if (k == 1 && !chain && !rsp_valid) ceq("R1 strobe lasts one cycle", cp_req, 0);
      if (rsp_valid) begin got = k; break; end
    end
    ack = 0; err = 0;
    to = (dly < 1 || dly > lim);
    ec = to ? lim : dly;
    ceq("R9 response strobe", rsp_valid, 1);
    ceq("R9/R11 cycle count", rsp_cycles, ec);
    ceq("R11 timeout flag", rsp_to, to);
    if (got != 0 && got != ec) ceq("R9 response cycle", got, ec);
    if (!to) begin
      ceq("R9 captured data", rsp_data, dv);
      ceq("R9 captured error", rsp_err, ev);
      ceq("R10 compare result", rsp_cf, exp_cf(chk, dv, ed, msk));
      if (!chain) ceq("R9 ready after completion", cmd_ready, 1);
    end else begin
      ceq("R12 reset pulse", cp_rst, 1);
      for (int i = 1; i <= 9; i++) begin
        @(negedge clk);
        ceq("R12 hold-off refuses", cmd_ready, 0);
        if (i == 1) ceq("R12 reset pulse ends", cp_rst, 0);
      end
      @(negedge clk);
      ceq("R12 ready after hold-off", cmd_ready, 1);
      busy = 0; stepf = 0; gof = 0;
    end
  endtask

  // plain port command; kind 0 ack, 1 step, 2 run-end
  task automatic port_cmd(input logic [4:0] op, input logic [15:0] data, input logic [2:0] rnum,
                          input logic [4:0] woff, input logic chk, input logic [15:0] mask,
                          input int dly, input logic [15:0] dv, input logic ev, input string rq);
    int kind = (op == OP_STEP) ? 1 : (op == OP_WRUN) ? 2 : 0;
    int lim = (kind == 1) ? lim_stp : (kind == 2) ? lim_run : lim_cmd;
    logic io = (op == OP_RIO || op == OP_WIO);
    logic [3:0] ef;
    logic to;
    case (op)
      OP_RMEMI, OP_RIO: ef = F_RMEM;
      OP_WMEMI, OP_WIO: ef = F_WMEM;
      OP_START: ef = F_STA;  OP_STOP: ef = F_STO; OP_CONT: ef = F_CONT;
      OP_STEP:  ef = F_STEP; OP_CRST: ef = F_RST;
      default:  ef = op[3:0];
    endcase
    if (kind == 1) begin busy = 1; stepf = 1; end
    if (kind == 2) begin busy = 1; gof = 1; end
    send(op, data, rnum, woff, chk, mask);
    ceq({rq, " R1 busy refuses"}, cmd_ready, 0);
    if (kind == 2) ceq({rq, " R8 no request for run wait"}, cp_req, 0);
    else begin
      ceq({rq, " R1 request"}, cp_req, 1);
      ceq({rq, " R1 function"}, cp_func, ef);
      ceq({rq, " R1 register"}, cp_rnum, rnum);
      ceq({rq, " R1 data"}, cp_din, data);
      if (io) begin
        ceq({rq, " R6 io address"}, cp_addr, {6'b0, 3'b111, m_base, woff, 1'b0});
        ceq({rq, " R6 io flags"}, {cp_racc, cp_e22, cp_map, cp_be}, {3'b100, m_be});
      end else begin
        ceq({rq, " R4 address"}, cp_addr, m_addr);
        ceq({rq, " R4 flags"}, {cp_racc, cp_e22, cp_map, cp_be}, {1'b0, m_e22, m_map, 2'b11});
      end
    end
    wait_done(dly, dv, ev, kind, lim, chk, data, mask, 1'b0, to);
    if ((op == OP_RMEMI || op == OP_WMEMI) && !to) m_addr = m_addr + 22'd2;
  endtask

  initial begin
    logic to;
    void'($urandom(32'd1234));
    #1;
    ceq("R14 ready in reset", cmd_ready, 1);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ceq("R14 ready after reset", cmd_ready, 1);
    ceq("R14 no request", cp_req, 0);
    ceq("R14 no port reset", cp_rst, 0);
    ceq("R14 no response", rsp_valid, 0);
    port_cmd(OP_RMEM, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 2, 16'h1111, 1'b0, "R14 addr zero");

    // R3, R2 address register
    local_op(OP_ALO, 16'hABCD);
    local_op(OP_AHI, 16'h00C5);
    port_cmd(OP_RMEM, 16'h0, 3'd0, 5'd0, 1'b1, 16'h00FF, 3, 16'h12AB, 1'b1, "R3 high write");
    local_op(OP_ALO, 16'h2468);
    port_cmd(OP_WMEM, 16'h5A5A, 3'd0, 5'd0, 1'b0, 16'h0, 1, 16'h0, 1'b0, "R2 low clears high");

    // R5, R6 I/O page
    local_op(OP_IOB, 16'h0FC0);
    port_cmd(OP_RIO, 16'h0, 3'd0, 5'd21, 1'b0, 16'h0, 4, 16'h7777, 1'b0, "R5 be default");
    local_op(OP_IOB, 16'h0141);
    port_cmd(OP_WIO, 16'hBEEF, 3'd0, 5'd3, 1'b0, 16'h0, 2, 16'h0, 1'b0, "R6 io write");
    port_cmd(OP_RMEM, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 1, 16'h0, 1'b0, "R4 after io");

    // R7 auto-increment
    local_op(OP_ALO, 16'h1000);
    port_cmd(OP_RMEMI, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 2, 16'h1, 1'b0, "R7 inc first");
    port_cmd(OP_WMEMI, 16'h2, 3'd0, 5'd0, 1'b0, 16'h0, 3, 16'h0, 1'b0, "R7 inc second");
    port_cmd(OP_RMEM, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 1, 16'h0, 1'b0, "R7 address advanced");

    // R8 wait kinds
    port_cmd(OP_STEP, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 5, 16'h0, 1'b0, "R8 step");
    port_cmd(OP_WRUN, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 20, 16'h0, 1'b0, "R8 run end");
    port_cmd(OP_CONT, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 1, 16'h0, 1'b0, "R8 continue");
    port_cmd(OP_WREG, 16'h0777, 3'd5, 5'd0, 1'b0, 16'h0, 2, 16'h0, 1'b0, "R1 register write");

    // R11 default and programmed timeouts, R12 hold-off, R7 no inc on timeout
    port_cmd(OP_RREG, 16'h0, 3'd2, 5'd0, 1'b0, 16'h0, 0, 16'h0, 1'b0, "R11 default timeout");
    local_op(OP_TCMD, 16'd5);
    port_cmd(OP_RMEMI, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 0, 16'h0, 1'b0, "R11 programmed timeout");
    port_cmd(OP_RMEM, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 5, 16'h3, 1'b0, "R7 no inc on timeout");
    local_op(OP_TSTP, 16'd3);
    port_cmd(OP_STEP, 16'h0, 3'd0, 5'd0, 1'b0, 16'h0, 4, 16'h0, 1'b0, "R11 step timeout");
    local_op(OP_TCMD, 16'd50);

    // R13 load PC and start
    send(OP_LDPC, 16'o1000, 3'd0, 5'd0, 1'b0, 16'h0);
    ceq("R13 first request", cp_req, 1);
    ceq("R13 write register func", cp_func, F_WREG);
    ceq("R13 register 7", cp_rnum, 3'd7);
    ceq("R13 PC data", cp_din, 16'o1000);
    wait_done(2, 16'h0, 1'b0, 0, lim_cmd, 1'b0, 16'h0, 16'h0, 1'b1, to);
    ceq("R13 start follows", cp_req, 1);
    ceq("R13 start func", cp_func, F_STA);
    wait_done(3, 16'h0, 1'b0, 0, lim_cmd, 1'b0, 16'h0, 16'h0, 1'b0, to);

    // R10 compare, mixed random stimulus
    for (int it = 0; it < 40; it++) begin
      logic [4:0]  op;
      logic [15:0] d, m, r;
      logic        c;
      case ($urandom % 4)
        0: op = OP_RREG;
        1: op = OP_RMEM;
        2: op = OP_RMEMI;
        default: op = OP_RIO;
      endcase
      d = 16'($urandom); m = 16'($urandom) & 16'h0F0F; c = 1'($urandom);
      r = ($urandom % 2 == 0) ? (d ^ (m & 16'($urandom))) : 16'($urandom);
      port_cmd(op, d, 3'($urandom), 5'($urandom), c, m, 1 + int'($urandom % 6), r,
               1'($urandom), "R10 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule